// File: doc/BRIEF.md
# Hot-Plug Slot Control and Status Registers

This block holds the slot control and slot status registers of a hot-plug capable downstream or root port, together with the event and interrupt logic behind them. Software reaches the two 16-bit registers through a byte-enabled write port and a combinational read port. The address decoder in front of the block selects one of the two registers. Slot hardware reports a card insertion or an unplug request on single-cycle event inputs. The block turns status and enable bits into a pending level. When that level changes it signals once: either as a one-cycle message pulse that carries the interrupt message number, or by moving a level-sensitive INTx line.

A control write can also carry out side effects. It can toggle the electromechanical interlock, and it can request that the card be detached when the slot is occupied and software powers it off with the power indicator off. Every control write is reported back as a command-completed event.

Top module: `hp_slot_regs`

## Requirements
- R1: After reset the control register reads 0x00C0 (attention indicator field bits 7:6 = 11, off; all else 0), the status register reads 0x0000, intxLevel, msgPulse and detachReq are 0.
- R2: Control fields are attention-button enable bit 0, presence-change enable bit 3, command-done enable bit 4, hot-plug interrupt enable bit 5, attention indicator bits 7:6, power indicator bits 9:8 (11 = off), power-off bit 10 (1 = off), interlock command bit 11. byteEn[0] writes bits 7:0 and byteEn[1] writes bits 15:8. A write shows on rdData one cycle later.
- R3: pending = bit 5 AND ((status bit 0 AND control bit 0) OR (status bit 3 AND control bit 3) OR (status bit 4 AND control bit 4)). A notification happens only when an evaluation changes pending. With msgIntEn=1 it is a one-cycle msgPulse with msgVec equal to intMsgNum. With msgIntEn=0, intxLevel takes the new pending value.
- R4: Raising events of which any is already set in status gives no notification.
- R5: A status write (regSel=1) clears status bits 0 (attention pressed), 3 (presence changed) and 4 (command done) where the low-lane data holds a 1. Pending is then recomputed with no message pulse. intxLevel drops if msgIntEn=0 and nothing remains pending.
- R6: Writing 1 to control bit 11 toggles the interlock status bit 7. Control bit 11 always reads 0.
- R7: If presence state (status bit 6) is 1 and a control write with byteEn[1] set has bit 10 = 1 and bits 9:8 = 11, then detachReq pulses for one cycle, status bit 6 clears and status bit 3 sets.
- R8: Every control write sets status bit 4 (command done), and the write is evaluated for notification together with its other effects.
- R9: insertEvt sets status bit 6 and raises bits 3 and 0. unplugReq raises bit 0 only.
- R10: An event input in the same cycle as a register write is dropped.
- R11: Control bits 15:12 and 2:1 and status bits 15:8, 5 and 2:1 read 0 and cannot be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects control, 1 selects status |
| byteEn | input | 2 | Byte lane enables for a write |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data of the selected register |
| insertEvt | input | 1 | Card inserted (one cycle) |
| unplugReq | input | 1 | Unplug requested (one cycle) |
| msgIntEn | input | 1 | Message interrupt mode enabled |
| intMsgNum | input | 5 | Interrupt message number |
| detachReq | output | 1 | One-cycle request to detach the card |
| msgPulse | output | 1 | One-cycle message interrupt |
| msgVec | output | 5 | Vector sent with msgPulse |
| intxLevel | output | 1 | Level INTx line |

## Verification
Every state change, detachReq, msgPulse/msgVec and the intxLevel update is due at the first rising edge after the stimulus is applied, because each passes through exactly one register. The bench drives on the falling edge and samples outputs 1 ns after the next rising edge. It then reads both registers through the combinational read port during an idle cycle that changes no state. A bench model derived from the requirements predicts each of these values for every operation in a sweep over the enable bits, both interrupt modes and each event kind.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
  localparam int RegW    = 16;
  localparam int EvW     = 3;
  localparam int EvAbp   = 0;
  localparam int EvPdc   = 1;
  localparam int EvCc    = 2;
  localparam logic [1:0] IndOff = 2'b11;

  typedef struct packed {
    logic           ctlWr;
    logic           staWr;
    logic           loLane;
    logic           hiLane;
    logic           evtGo;
    logic           setPds;
    logic [EvW-1:0] raise;
  } hpStrobe_t;
endpackage

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hp_slot_pkg::*;
(
  input  logic       wrEn,
  input  logic       regSel,
  input  logic [1:0] byteEn,
  input  logic       insertEvt,
  input  logic       unplugReq,
  output hpStrobe_t  strobe
);
  logic           anyWr;
  logic [EvW-1:0] raiseMask;

  assign anyWr = wrEn && (|byteEn);

  always_comb begin
    raiseMask = '0;
    if (insertEvt) begin
      raiseMask[EvPdc] = 1'b1;
      raiseMask[EvAbp] = 1'b1;
    end
    if (unplugReq) raiseMask[EvAbp] = 1'b1;
  end

  // R10: a register write wins over a simultaneous hardware event
  always_comb begin
    strobe.ctlWr  = anyWr && !regSel;
    strobe.staWr  = anyWr && regSel;
    strobe.loLane = byteEn[0];
    strobe.hiLane = byteEn[1];
    strobe.evtGo  = !anyWr && (|raiseMask);
    strobe.setPds = !anyWr && insertEvt;
    strobe.raise  = raiseMask;
  end
endmodule

// File: rtl/hp_slot_datapath.sv
module hp_slot_datapath
  import hp_slot_pkg::*;
#(
  parameter int VecW = 5
) (
  input  logic            clk,
  input  logic            rstN,
  input  hpStrobe_t       strobe,
  input  logic            regSel,
  input  logic [RegW-1:0] wrData,
  input  logic            msgIntEn,
  input  logic [VecW-1:0] intMsgNum,
  output logic [RegW-1:0] rdData,
  output logic            detachReq,
  output logic            msgPulse,
  output logic [VecW-1:0] msgVec,
  output logic            intxLevel
);
  // control state
  logic       abpe, pdce, ccie, hpie, pcc;
  logic [1:0] aic, pic;
  // status state
  logic [EvW-1:0] evt;
  logic           pds, eis;
  logic           pendReg;

  logic       nAbpe, nPdce, nCcie, nHpie, nPcc;
  logic [1:0] nAic, nPic;
  logic [EvW-1:0] nEvt;
  logic       nPds, nEis, nPend, pendCalc;
  logic       lockFlip, detachHit, alreadySet, notify, clrIntx;
  logic [RegW-1:0] ctlWord, staWord;
  logic       unusedWrBits;

  assign unusedWrBits = ^{wrData[15:12], wrData[2:1]};

  // R11: reserved bits read zero; R6: interlock command reads zero
  assign ctlWord = {4'b0, 1'b0, pcc, pic, aic, hpie, ccie, pdce, 2'b0, abpe};
  assign staWord = {8'b0, eis, pds, 1'b0, evt[EvCc], evt[EvPdc], 2'b0, evt[EvAbp]};
  assign rdData  = regSel ? staWord : ctlWord;

  always_comb begin
    nAbpe = abpe; nPdce = pdce; nCcie = ccie; nHpie = hpie;
    nAic  = aic;  nPic  = pic;  nPcc  = pcc;
    if (strobe.ctlWr && strobe.loLane) begin
      nAbpe = wrData[0];
      nPdce = wrData[3];
      nCcie = wrData[4];
      nHpie = wrData[5];
      nAic  = wrData[7:6];
    end
    if (strobe.ctlWr && strobe.hiLane) begin
      nPic = wrData[9:8];
      nPcc = wrData[10];
    end

    lockFlip  = strobe.ctlWr && strobe.hiLane && wrData[11];
    nEis      = eis ^ lockFlip;
    detachHit = strobe.ctlWr && strobe.hiLane && pds && wrData[10] &&
                (wrData[9:8] == IndOff);
    nPds      = detachHit ? 1'b0 : (strobe.setPds ? 1'b1 : pds);

    nEvt = evt;
    if (strobe.staWr && strobe.loLane)
      nEvt = nEvt & ~{wrData[4], wrData[3], wrData[0]};
    if (detachHit)    nEvt[EvPdc] = 1'b1;
    if (strobe.ctlWr) nEvt[EvCc]  = 1'b1;
    alreadySet = |(evt & strobe.raise);
    if (strobe.evtGo) nEvt = nEvt | strobe.raise;

    pendCalc = nHpie && (|(nEvt & {nCcie, nPdce, nAbpe}));

    nPend   = pendReg;
    notify  = 1'b0;
    clrIntx = 1'b0;
    if (strobe.ctlWr) begin
      nPend  = pendCalc;
      notify = (pendCalc != pendReg);
    end else if (strobe.evtGo && !alreadySet) begin
      nPend  = pendCalc;
      notify = (pendCalc != pendReg);
    end else if (strobe.staWr) begin
      nPend   = pendCalc;
      clrIntx = !msgIntEn && !pendCalc;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      abpe <= 1'b0; pdce <= 1'b0; ccie <= 1'b0; hpie <= 1'b0;
      aic  <= IndOff; pic <= 2'b00; pcc <= 1'b0;
      evt  <= '0; pds <= 1'b0; eis <= 1'b0;
      pendReg   <= 1'b0;
      intxLevel <= 1'b0;
      msgPulse  <= 1'b0;
      msgVec    <= '0;
      detachReq <= 1'b0;
    end else begin
      abpe <= nAbpe; pdce <= nPdce; ccie <= nCcie; hpie <= nHpie;
      aic  <= nAic;  pic  <= nPic;  pcc  <= nPcc;
      evt  <= nEvt;  pds  <= nPds;  eis  <= nEis;
      pendReg   <= nPend;
      detachReq <= detachHit;
      msgPulse  <= notify && msgIntEn;
      if (notify && msgIntEn) msgVec <= intMsgNum;
      if (notify && !msgIntEn) intxLevel <= nPend;
      else if (clrIntx)        intxLevel <= 1'b0;
    end
  end

  // R8: command done set after any control write
  p_ctl_write_cc_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ctlWr |=> evt[EvCc]);

  // R6: interlock toggles on a written 1
  p_lock_toggle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ctlWr && strobe.hiLane && wrData[11]) |=> (eis != $past(eis)));

  // R7: detach leaves the slot empty with presence change flagged
  p_detach_effects_r7: assert property (@(posedge clk) disable iff (!rstN)
    detachReq |-> (!pds && evt[EvPdc]));

  // R3: message pulses only in message mode
  p_msg_mode_only_r3: assert property (@(posedge clk) disable iff (!rstN)
    msgPulse |-> $past(msgIntEn));

  // R3: INTx never moves in message mode
  p_intx_mode_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(intxLevel) |-> !$past(msgIntEn));

  // R5: written-one clears attention status
  p_w1c_abp_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.staWr && strobe.loLane && wrData[0]) |=> !evt[EvAbp]);

  // R5: status writes never send messages
  p_status_no_msg_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.staWr |=> !msgPulse);

  // R4: re-raising a set event stays silent
  p_no_renotify_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.evtGo && (|(evt & strobe.raise))) |=> (!msgPulse && $stable(intxLevel)));
endmodule

// File: rtl/hp_slot_regs.sv
module hp_slot_regs
  import hp_slot_pkg::*;
#(
  parameter int VecW = 5
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic            regSel,
  input  logic [1:0]      byteEn,
  input  logic [RegW-1:0] wrData,
  output logic [RegW-1:0] rdData,
  input  logic            insertEvt,
  input  logic            unplugReq,
  input  logic            msgIntEn,
  input  logic [VecW-1:0] intMsgNum,
  output logic            detachReq,
  output logic            msgPulse,
  output logic [VecW-1:0] msgVec,
  output logic            intxLevel
);
  hpStrobe_t strobe;

  hp_slot_ctrl uCtrl (
    .wrEn      (wrEn),
    .regSel    (regSel),
    .byteEn    (byteEn),
    .insertEvt (insertEvt),
    .unplugReq (unplugReq),
    .strobe    (strobe)
  );

  hp_slot_datapath #(.VecW(VecW)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .regSel    (regSel),
    .wrData    (wrData),
    .msgIntEn  (msgIntEn),
    .intMsgNum (intMsgNum),
    .rdData    (rdData),
    .detachReq (detachReq),
    .msgPulse  (msgPulse),
    .msgVec    (msgVec),
    .intxLevel (intxLevel)
  );
endmodule

// File: tb/tb_hp_slot_regs.sv
`timescale 1ns/1ps
module tb_hp_slot_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        regSel = 1'b0;
  logic [1:0]  byteEn = 2'b00;
  logic [15:0] wrData = 16'h0;
  logic [15:0] rdData;
  logic        insertEvt = 1'b0;
  logic        unplugReq = 1'b0;
  logic        msgIntEn = 1'b0;
  logic [4:0]  intMsgNum = 5'd0;
  logic        detachReq, msgPulse, intxLevel;
  logic [4:0]  msgVec;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  // bench model state
  logic [15:0] mCtl, mSta;
  logic        mPend, mIntx, expMsg, expDet;
  logic [4:0]  expVec;

  always #2.5 clk = ~clk;

  hp_slot_regs dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regSel(regSel), .byteEn(byteEn),
    .wrData(wrData), .rdData(rdData), .insertEvt(insertEvt), .unplugReq(unplugReq),
    .msgIntEn(msgIntEn), .intMsgNum(intMsgNum), .detachReq(detachReq),
    .msgPulse(msgPulse), .msgVec(msgVec), .intxLevel(intxLevel)
  );

  task automatic check(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%04h expected 0x%04h", tag, what, act, exp);
    end
  endtask

  function automatic logic pendOf();
    return mCtl[5] && (|(mSta & mCtl & 16'h0019));
  endfunction

  task automatic notifyModel(input logic newP);
    if (newP != mPend) begin
      if (msgIntEn) begin expMsg = 1'b1; expVec = intMsgNum; end
      else mIntx = newP;
    end
    mPend = newP;
  endtask

  // one operation: drive, step one edge, check outputs, then read registers back
  task automatic doOp(input logic wr, input logic sel, input logic [1:0] be,
                      input logic [15:0] d, input logic ins, input logic unp,
                      input string tag);
    logic [15:0] rm;
    logic        newP;
    @(negedge clk);
    wrEn = wr; regSel = sel; byteEn = be; wrData = d;
    insertEvt = ins; unplugReq = unp;
    expMsg = 1'b0; expDet = 1'b0;
    if (wr && (|be)) begin
      if (!sel) begin
        if (be[0]) mCtl[7:0]  = d[7:0] & 8'hF9;
        if (be[1]) mCtl[15:8] = d[15:8] & 8'h07;
        if (be[1] && d[11]) mSta[7] = ~mSta[7];
        expDet = be[1] && mSta[6] && d[10] && (d[9:8] == 2'b11);
        if (expDet) begin mSta[6] = 1'b0; mSta[3] = 1'b1; end
        mSta[4] = 1'b1;
        notifyModel(pendOf());
      end else begin
        if (be[0]) mSta = mSta & ~(d & 16'h0019);
        newP = pendOf();
        mPend = newP;
        if (!msgIntEn && !newP) mIntx = 1'b0;
      end
    end else if (ins || unp) begin
      rm = (ins ? 16'h0009 : 16'h0) | (unp ? 16'h0001 : 16'h0);
      if (ins) mSta[6] = 1'b1;
      if (|(mSta & rm)) mSta = mSta | rm;
      else begin
        mSta = mSta | rm;
        notifyModel(pendOf());
      end
    end
    @(posedge clk); #1;
    check(tag, "msgPulse", {15'b0, msgPulse}, {15'b0, expMsg});
    if (expMsg) check(tag, "msgVec", {11'b0, msgVec}, {11'b0, expVec});
    check(tag, "intxLevel", {15'b0, intxLevel}, {15'b0, mIntx});
    check(tag, "detachReq", {15'b0, detachReq}, {15'b0, expDet});
    @(negedge clk);
    wrEn = 1'b0; byteEn = 2'b00; insertEvt = 1'b0; unplugReq = 1'b0;
    regSel = 1'b0; #1;
    check(tag, "control readback", rdData, mCtl);
    regSel = 1'b1; #1;
    check(tag, "status readback", rdData, mSta);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    mCtl = 16'h00C0; mSta = 16'h0; mPend = 1'b0; mIntx = 1'b0;
    expMsg = 1'b0; expDet = 1'b0; expVec = 5'd0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    // R1: reset values
    regSel = 1'b0; #1; check("R1", "control reset", rdData, 16'h00C0);
    regSel = 1'b1; #1; check("R1", "status reset", rdData, 16'h0000);
    check("R1", "intx reset", {15'b0, intxLevel}, 16'h0);
    check("R1", "msg reset", {15'b0, msgPulse}, 16'h0);
    check("R1", "detach reset", {15'b0, detachReq}, 16'h0);

    // R11: all-ones write, reserved bits stay zero; R6 interlock toggles
    doOp(1, 0, 2'b11, 16'hFFFF, 0, 0, "R11");
    doOp(1, 1, 2'b11, 16'hFFFF, 0, 0, "R11");
    // R2: lane enables
    doOp(1, 0, 2'b10, 16'h0000, 0, 0, "R2");
    doOp(1, 0, 2'b01, 16'h00C0, 0, 0, "R2");
    doOp(1, 0, 2'b10, 16'h0300, 0, 0, "R2");
    // R6: interlock toggle twice
    doOp(1, 0, 2'b10, 16'h0800, 0, 0, "R6");
    doOp(1, 0, 2'b10, 16'h0800, 0, 0, "R6");
    doOp(1, 1, 2'b01, 16'h0019, 0, 0, "R5");

    // R3/R8/R9/R5 sweep over modes, enables and event kinds
    for (int m = 0; m < 2; m++) begin
      for (int en = 0; en < 16; en++) begin
        for (int ev = 0; ev < 3; ev++) begin
          logic [15:0] cw;
          msgIntEn  = m[0];
          intMsgNum = 5'(en * 3 + ev);
          cw = 16'h00C0 | (en[0] ? 16'h0001 : 16'h0) | (en[1] ? 16'h0008 : 16'h0) |
               (en[2] ? 16'h0010 : 16'h0) | (en[3] ? 16'h0020 : 16'h0);
          doOp(1, 1, 2'b01, 16'h0019, 0, 0, "R5");
          doOp(1, 0, 2'b01, cw, 0, 0, "R8");
          doOp(1, 1, 2'b01, 16'h0010, 0, 0, "R5");
          if (ev == 0) doOp(0, 0, 2'b00, 16'h0, 1, 0, "R9");
          else if (ev == 1) doOp(0, 0, 2'b00, 16'h0, 0, 1, "R9");
          else doOp(1, 0, 2'b01, cw, 0, 0, "R3");
          // R4: repeat raise of an already set event
          doOp(0, 0, 2'b00, 16'h0, 0, 1, "R4");
          doOp(1, 1, 2'b01, 16'h0009, 0, 0, "R5");
        end
      end
    end

    // R7: detach on occupied slot, and the near misses
    msgIntEn = 1'b0;
    doOp(1, 1, 2'b01, 16'h0019, 0, 0, "R5");
    doOp(1, 0, 2'b11, 16'h00E8, 0, 0, "R3");
    doOp(0, 0, 2'b00, 16'h0, 1, 0, "R9");
    doOp(1, 0, 2'b10, 16'h0600, 0, 0, "R7");
    doOp(1, 0, 2'b10, 16'h0300, 0, 0, "R7");
    doOp(1, 0, 2'b10, 16'h0700, 0, 0, "R7");
    doOp(1, 0, 2'b10, 16'h0700, 0, 0, "R7");
    doOp(1, 1, 2'b01, 16'h0019, 0, 0, "R5");

    // R10: write in the same cycle as an event drops the event
    doOp(1, 1, 2'b01, 16'h0000, 1, 1, "R10");
    doOp(1, 0, 2'b01, 16'h00C0, 1, 0, "R10");
    doOp(1, 1, 2'b00, 16'h0000, 0, 0, "R10");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule